// File: doc/BRIEF.md
# EEPROM Write/Read Sequencer with Acknowledge Polling

This block sits between a simple request port and a byte-level two-wire (I2C) master engine. It turns one request into the full command sequence for a serial EEPROM. A byte write places one data byte at a 16-bit memory address. A random read sets the device's address pointer and then fetches one byte. The block issues each command to the engine, waits for the engine's response, and then picks the next command from the acknowledge result.

A serial EEPROM stays silent while its internal programming cycle runs. For that reason the block does not wait a fixed time after a write. It re-addresses the device straight after the closing stop, sending a repeated start and the write control byte each time. The first acknowledged address shows that programming has finished. The block then closes the bus with a stop and reports completion. A bounded number of unanswered polls ends the request with an error. A missing acknowledge on any byte of a normal transfer also ends it with an error.

Top module: `eeprom_ack_poll_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `done` and `err` are 0, and no command is issued (`cmd_valid` 0).
- R2: The control byte is the 7-bit device address (default 0x50) in bits 7:1, with bit 0 set to 0 for write and 1 for read. The default bytes are therefore 0xA0 and 0xA1.
- R3: A write request issues START, WRITE(control-write), WRITE(address high), WRITE(address low), WRITE(data), STOP, in that order. Engine op codes: 0 START, 1 STOP, 2 WRITE, 3 READ.
- R4: A read request issues START, WRITE(control-write), WRITE(address high), WRITE(address low), START, WRITE(control-read), READ, STOP. `rd_data` carries the byte that was read in the cycle `done` is high.
- R5: After the write's STOP, the block repeats START plus WRITE(control-write) for as long as that byte is not acknowledged. On the first acknowledge it issues one STOP and then signals `done` with `err` 0.
- R6: After MAX_POLLS consecutive unacknowledged polls, the block issues a STOP and ends the request with `done` and `err` both high.
- R7: A missing acknowledge on any written byte of a normal transfer makes the block issue a STOP at once and end with `done` and `err` high. It does not poll in that case.
- R8: A request is taken only while `req_ready` is 1. A `req_valid` pulse while busy starts no commands and is not queued.
- R9: `done` is high for exactly one cycle per request. `err` is high only together with `done`.
- R10: At most one engine command is outstanding. `cmd_valid` is a one-cycle pulse, and no further command follows until `rsp_valid` has been seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_rnw | input | 1 | 1 = random read, 0 = byte write |
| req_addr | input | 16 | EEPROM memory address |
| req_wdata | input | 8 | Data byte for writes |
| req_ready | output | 1 | Block is idle and will take a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request failed (valid with done) |
| rd_data | output | 8 | Byte read (valid with done on reads) |
| cmd_valid | output | 1 | Engine command strobe |
| cmd_op | output | 2 | Engine op: 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmd_byte | output | 8 | Byte to send for WRITE |
| rsp_valid | input | 1 | Engine finished the current command |
| rsp_ack | input | 1 | Device acknowledged the written byte |
| rsp_data | input | 8 | Byte returned by READ |

## Verification
The bench drives a behavioural EEPROM that refuses addressing for a set number of polls after each programmed write. It runs writes with a non-zero busy count and with a zero busy count, which shows that the poll loop repeats and also that it exits on the first acknowledge. A read after a write checks both the restart with the read control byte and that the stored value comes back. Three failure patterns are injected: a busy period longer than the poll limit, a refused data byte, and a refused control byte. These separate the timeout path from the abort path and confirm that no polling follows an abort. A request strobed in the middle of a transfer confirms that busy-time requests leave no trace on the engine port.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
    localparam int BYTE_W     = 8;
    localparam int MEM_ADDR_W = 16;
    localparam int DEV_W      = 7;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } eng_op_e;

    typedef enum logic [3:0] {
        ST_START, ST_CTRLW, ST_AHI, ST_ALO, ST_DATA, ST_STOPW,
        ST_PSTART, ST_PCTRL, ST_PSTOP,
        ST_RSTART, ST_CTRLR, ST_RDATA, ST_STOPR, ST_ABORT
    } step_e;

    typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_WAIT} phase_e;

    typedef struct packed {
        logic                  rnw;
        logic [MEM_ADDR_W-1:0] addr;
        logic [BYTE_W-1:0]     wdata;
    } req_t;

    typedef struct packed {
        eng_op_e           op;
        logic [BYTE_W-1:0] data;
    } eng_cmd_t;

    function automatic logic [BYTE_W-1:0] ctrl_byte(input logic [DEV_W-1:0] dev,
                                                    input logic rnw);
        return {dev, rnw};
    endfunction

    function automatic eng_cmd_t step_cmd(input step_e st, input logic [DEV_W-1:0] dev,
                                          input req_t r);
        eng_cmd_t c;
        c.op   = OP_WRITE;
        c.data = '0;
        case (st)
            ST_START, ST_PSTART, ST_RSTART: c.op = OP_START;
            ST_STOPW, ST_PSTOP, ST_STOPR, ST_ABORT: c.op = OP_STOP;
            ST_RDATA: c.op = OP_READ;
            ST_CTRLW, ST_PCTRL: c.data = ctrl_byte(dev, 1'b0);
            ST_CTRLR: c.data = ctrl_byte(dev, 1'b1);
            ST_AHI:   c.data = r.addr[MEM_ADDR_W-1 -: BYTE_W];
            ST_ALO:   c.data = r.addr[BYTE_W-1:0];
            ST_DATA:  c.data = r.wdata;
            default:  c.op = OP_STOP;
        endcase
        return c;
    endfunction

    function automatic logic step_is_last(input step_e st);
        return (st == ST_PSTOP) || (st == ST_STOPR) || (st == ST_ABORT);
    endfunction
endpackage

// File: rtl/eeprom_poll_ctr.sv
module eeprom_poll_ctr #(
    parameter int MAX_POLLS = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

    logic [CNT_W-1:0] cnt;

    assign at_limit = (cnt == CNT_W'(MAX_POLLS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc && !at_limit) cnt <= cnt + 1'b1;
    end

    // R6: the count never passes the last permitted poll
    p_poll_bound_r6: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) < MAX_POLLS);
endmodule

// File: rtl/eeprom_req_hold.sv
module eeprom_req_hold
    import eeprom_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  req_t d,
    output req_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (fire) q <= d;
    end

    // R8: the held request changes only when a request is taken
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(q));
endmodule

// File: rtl/eeprom_seq_fsm.sv
module eeprom_seq_fsm
    import eeprom_seq_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_fire,
    input  req_t              req,
    input  logic              rsp_valid,
    input  logic              rsp_ack,
    input  logic [BYTE_W-1:0] rsp_data,
    input  logic              poll_at_limit,
    output logic              poll_clr,
    output logic              poll_inc,
    output logic              cmd_valid,
    output eng_cmd_t          cmd,
    output logic              idle,
    output logic              done,
    output logic              err,
    output logic [BYTE_W-1:0] rd_data
);
    phase_e phase;
    step_e  step, nxt;
    logic   resp_here;

    assign resp_here = (phase == PH_WAIT) && rsp_valid;
    assign cmd_valid = (phase == PH_ISSUE);
    assign cmd       = step_cmd(step, DEV_ADDR, req);
    assign idle      = (phase == PH_IDLE);
    assign poll_clr  = resp_here && (step == ST_STOPW);
    assign poll_inc  = resp_here && (step == ST_PCTRL) && !rsp_ack;

    always_comb begin
        nxt = ST_ABORT;
        case (step)
            ST_START:  nxt = ST_CTRLW;
            ST_CTRLW:  nxt = rsp_ack ? ST_AHI : ST_ABORT;
            ST_AHI:    nxt = rsp_ack ? ST_ALO : ST_ABORT;
            ST_ALO:    nxt = !rsp_ack ? ST_ABORT : (req.rnw ? ST_RSTART : ST_DATA);
            ST_DATA:   nxt = rsp_ack ? ST_STOPW : ST_ABORT;
            ST_STOPW:  nxt = ST_PSTART;
            ST_PSTART: nxt = ST_PCTRL;
            ST_PCTRL:  nxt = rsp_ack ? ST_PSTOP : (poll_at_limit ? ST_ABORT : ST_PSTART);
            ST_RSTART: nxt = ST_CTRLR;
            ST_CTRLR:  nxt = rsp_ack ? ST_RDATA : ST_ABORT;
            ST_RDATA:  nxt = ST_STOPR;
            default:   nxt = ST_ABORT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            step    <= ST_START;
            done    <= 1'b0;
            err     <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (phase)
                PH_IDLE: if (req_fire) begin
                    step  <= ST_START;
                    phase <= PH_ISSUE;
                end
                PH_ISSUE: phase <= PH_WAIT;
                PH_WAIT: if (rsp_valid) begin
                    if (step == ST_RDATA) rd_data <= rsp_data;
                    if (step_is_last(step)) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                        err   <= (step == ST_ABORT);
                    end else begin
                        step  <= nxt;
                        phase <= PH_ISSUE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R10: a command strobe lasts one cycle
    p_cmd_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);
    // R10: no new command while one is outstanding and unanswered
    p_one_outstanding_r10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT && !rsp_valid) |=> !cmd_valid);
    // R9: error only alongside completion
    p_err_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        err |-> done);
    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8: completion leaves the block ready for the next request
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> idle);
endmodule

// File: rtl/eeprom_ack_poll_seq.sv
module eeprom_ack_poll_seq
    import eeprom_seq_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h50,
    parameter int         MAX_POLLS = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_rnw,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_wdata,
    output logic        req_ready,
    output logic        done,
    output logic        err,
    output logic [7:0]  rd_data,
    output logic        cmd_valid,
    output logic [1:0]  cmd_op,
    output logic [7:0]  cmd_byte,
    input  logic        rsp_valid,
    input  logic        rsp_ack,
    input  logic [7:0]  rsp_data
);
    req_t     req_in, req_q;
    eng_cmd_t cmd;
    logic     fire, idle, poll_clr, poll_inc, poll_at_limit;

    assign req_in    = '{rnw: req_rnw, addr: req_addr, wdata: req_wdata};
    assign fire      = req_valid && idle;
    assign req_ready = idle;
    assign cmd_op    = cmd.op;
    assign cmd_byte  = cmd.data;

    eeprom_req_hold u_hold (
        .clk(clk), .rst(rst), .fire(fire), .d(req_in), .q(req_q)
    );

    eeprom_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_poll (
        .clk(clk), .rst(rst), .clr(poll_clr), .inc(poll_inc), .at_limit(poll_at_limit)
    );

    eeprom_seq_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst(rst), .req_fire(fire), .req(req_q),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_data(rsp_data),
        .poll_at_limit(poll_at_limit), .poll_clr(poll_clr), .poll_inc(poll_inc),
        .cmd_valid(cmd_valid), .cmd(cmd), .idle(idle),
        .done(done), .err(err), .rd_data(rd_data)
    );
endmodule

// File: tb/tb_eeprom_ack_poll_seq.sv
module tb_eeprom_ack_poll_seq;
    localparam int TB_MAX = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_rnw = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, done, err, cmd_valid;
    logic [7:0] rd_data, cmd_byte;
    logic [1:0] cmd_op;
    logic rsp_valid = 1'b0, rsp_ack = 1'b0;
    logic [7:0] rsp_data = '0;

    always #4 clk = ~clk;

    eeprom_ack_poll_seq #(.DEV_ADDR(7'h50), .MAX_POLLS(TB_MAX)) dut (.*);

    int n_checks = 0, n_fail = 0, cyc = 0;

    // behavioural EEPROM responder
    logic [7:0] mem [0:255];
    logic [7:0] wlog [0:63];
    int wn = 0, n_start = 0, n_stop = 0, n_read = 0, n_cmd = 0, poll_nacks = 0;
    int prog_cfg = 0, prog_busy = 0, nack_at = -1, bidx = 0, dly = 0, done_cnt = 0;
    logic [1:0] cop = 2'd0, last_op = 2'd0;
    logic [7:0] cb = '0, pend_data = '0;
    logic [15:0] ptr = '0;
    bit pend_wr = 0;

    always @(negedge clk) begin
        cyc++;
        if (done) done_cnt++;
        rsp_valid <= 1'b0;
        if (dly > 0) begin
            dly--;
            if (dly == 0) begin
                rsp_valid <= 1'b1;
                rsp_ack   <= 1'b1;
                last_op = cop;
                case (cop)
                    2'd0: begin bidx = 0; n_start++; end
                    2'd1: begin
                        n_stop++;
                        if (pend_wr) begin mem[ptr[7:0]] = pend_data; prog_busy = prog_cfg; end
                        pend_wr = 0;
                    end
                    2'd2: begin
                        if (wn < 64) wlog[wn] = cb;
                        wn++;
                        if (bidx == 0) begin
                            if (cb[7:1] != 7'h50) rsp_ack <= 1'b0;
                            else if (prog_busy > 0) begin
                                rsp_ack <= 1'b0; prog_busy--; poll_nacks++;
                            end
                        end else if (bidx == 1) ptr[15:8] = cb;
                        else if (bidx == 2) ptr[7:0] = cb;
                        else if (bidx == 3) begin pend_data = cb; pend_wr = 1; end
                        if (nack_at == bidx) begin rsp_ack <= 1'b0; if (bidx == 3) pend_wr = 0; end
                        bidx++;
                    end
                    default: begin rsp_data <= mem[ptr[7:0]]; rsp_ack <= 1'b0; n_read++; end
                endcase
            end
        end
        if (cmd_valid) begin cop = cmd_op; cb = cmd_byte; dly = 2; n_cmd++; end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        wn = 0; n_start = 0; n_stop = 0; n_read = 0; poll_nacks = 0; done_cnt = 0;
    endtask

    logic got_err;
    logic [7:0] got_rd;

    task automatic run_req(input bit rnw, input logic [15:0] a, input logic [7:0] d,
                           input bit busy_poke);
        int n;
        clear_log();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_rnw = rnw; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 5000) begin
            if (busy_poke && n == 3) begin
                req_valid = 1'b1; req_rnw = 1'b1; req_addr = 16'h3333;
            end else req_valid = 1'b0;
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        if (n >= 5000) chk("watchdog: request never completed", 0, 1);
        got_err = err; got_rd = rd_data;
        @(negedge clk); @(negedge clk);
        chk("R9 done pulse count", done_cnt, 1);
    endtask

    task automatic t_reset();
        chk("R1 req_ready after reset", req_ready, 1);
        chk("R1 done after reset", done, 0);
        chk("R1 err after reset", err, 0);
        chk("R1 cmd_valid after reset", cmd_valid, 0);
    endtask

    task automatic t_write_polled();
        prog_cfg = 3;
        run_req(0, 16'h1234, 8'h56, 0);
        chk("R5 err", got_err, 0);
        chk("R2 R3 control write byte", wlog[0], 8'hA0);
        chk("R3 address high", wlog[1], 8'h12);
        chk("R3 address low", wlog[2], 8'h34);
        chk("R3 data byte", wlog[3], 8'h56);
        chk("R5 poll control byte", wlog[4], 8'hA0);
        chk("R5 nacked polls", poll_nacks, 3);
        chk("R5 bytes written (4 + 4 polls)", wn, 8);
        chk("R5 starts (1 + 4 polls)", n_start, 5);
        chk("R5 stops", n_stop, 2);
        chk("R5 last op is STOP", last_op, 1);
        chk("R3 memory written", mem[8'h34], 8'h56);
    endtask

    task automatic t_read_back();
        run_req(1, 16'h1234, 8'h00, 0);
        chk("R4 err", got_err, 0);
        chk("R4 rd_data", got_rd, 8'h56);
        chk("R4 ctrl write", wlog[0], 8'hA0);
        chk("R4 addr hi", wlog[1], 8'h12);
        chk("R4 addr lo", wlog[2], 8'h34);
        chk("R2 R4 control read byte", wlog[3], 8'hA1);
        chk("R4 bytes written", wn, 4);
        chk("R4 starts", n_start, 2);
        chk("R4 reads", n_read, 1);
        chk("R4 stops", n_stop, 1);
    endtask

    task automatic t_write_fast();
        prog_cfg = 0;
        run_req(0, 16'h0042, 8'hC3, 0);
        chk("R5 immediate ack err", got_err, 0);
        chk("R5 single poll bytes", wn, 5);
        chk("R5 no nacked polls", poll_nacks, 0);
        run_req(1, 16'h0042, 8'h00, 0);
        chk("R4 read after fast write", got_rd, 8'hC3);
    endtask

    task automatic t_timeout();
        prog_cfg = 100;
        run_req(0, 16'h2040, 8'h77, 0);
        chk("R6 err on timeout", got_err, 1);
        chk("R6 nacked polls equal limit", poll_nacks, TB_MAX);
        chk("R6 stops", n_stop, 2);
        chk("R6 last op is STOP", last_op, 1);
        prog_cfg = 0; prog_busy = 0;
    endtask

    task automatic t_data_nack();
        nack_at = 3;
        run_req(0, 16'h0011, 8'h99, 0);
        nack_at = -1;
        chk("R7 err on data nack", got_err, 1);
        chk("R7 no polling after abort", wn, 4);
        chk("R7 one stop", n_stop, 1);
        chk("R7 last op is STOP", last_op, 1);
        run_req(1, 16'h0011, 8'h00, 0);
        chk("R7 rejected byte not stored", got_rd, 8'h00);
    endtask

    task automatic t_ctrl_nack();
        nack_at = 0;
        run_req(0, 16'h0022, 8'h44, 0);
        nack_at = -1;
        chk("R7 err on control nack", got_err, 1);
        chk("R7 only control byte sent", wn, 1);
        chk("R7 one stop", n_stop, 1);
    endtask

    task automatic t_busy_ignore();
        int c0;
        run_req(0, 16'h0100, 8'h5A, 1);
        chk("R8 write finished cleanly", got_err, 0);
        chk("R8 only write bytes issued", wn, 5);
        c0 = n_cmd;
        repeat (20) @(negedge clk);
        chk("R8 no command from busy-time request", n_cmd, c0);
        chk("R8 ready afterwards", req_ready, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_polled();
        t_read_back();
        t_write_fast();
        t_timeout();
        t_data_nack();
        t_ctrl_nack();
        t_busy_ignore();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule